// File: doc/BRIEF.md
# Scan-Clock Cycle Counter and Serial Signature Compactor

This block gives a test controller a way to run built-in self test on one local chain while other chains are being scanned. It holds a 32-bit count of test-clock cycles that runs down to zero and stops there. It also holds a 16-bit linear-feedback signature register that folds one serial test-data bit into its state on every clock. Decoded instruction codes start and stop each of the two functions separately. A sticky flag reports that the running count has reached zero.

Both registers are reached through one data-register path. The test controller selects the counter or the signature, then drives the usual capture, shift and update strobes. A count is written by shifting it in and updating. The signature is read by capturing it and shifting it out. The block does not choose which port supplies the sampled data bit. Its clock is the test clock, and its reset is synchronous and active high.

Top module: `tck_bist_unit`

## Requirements
- R1: While `rst` is high, the next clock edge clears the count, the terminal flag and the signature to zero and stops both functions. `tdo` is then 0 with no path selected.
- R2: `ctl_op` code 1 starts the counter and code 2 stops it, from the next clock edge on. Codes 0, 5, 6 and 7 change nothing.
- R3: While running, the count drops by exactly one on each clock edge. Once it reaches zero it stays at zero and does not wrap. While stopped, the count holds.
- R4: `tc_flag` is set on the edge after one in which the counter is running and the count is zero. It stays set until a count is loaded, and the load clears it. A zero count that is not running never sets it.
- R5: While the signature function is running, each edge replaces the signature S with (S<<1) XOR (0x1021 if S[15] XOR `sample_bit` is 1, else 0). This is the polynomial x^16+x^12+x^5+1.
- R6: `ctl_op` code 3 starts the signature function and code 4 stops it, from the next edge on. While it is stopped the signature holds, and the counter codes never affect it.
- R7: `path_sel` code 1 selects the counter. Capture copies the present count into the 32-bit scan stage. Shift moves `tdi` into bit 31, shifting right, and presents bit 0 on `tdo` (LSB first). Update writes the stage into the count, and that write takes priority over a decrement in the same cycle.
- R8: `path_sel` code 2 selects the signature. Capture copies the signature, zero-extended, into the stage. Shift moves `tdi` into bit 15 and shifts the low 16 bits right, leaving the upper bits alone. Update does not change the signature.
- R9: `tdo` is stage bit 0 when `path_sel` is 1 or 2, and 0 for codes 0 and 3. Capture takes priority over shift, and a strobe has no effect on the stage when no path is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_op | input | 3 | Decoded control code: 1/2 counter start/stop, 3/4 signature start/stop |
| path_sel | input | 2 | Register selected into the scan path: 1 counter, 2 signature |
| capture_dr | input | 1 | Capture strobe for the selected register |
| shift_dr | input | 1 | Shift strobe for the selected register |
| update_dr | input | 1 | Update strobe; writes the count when the counter is selected |
| tdi | input | 1 | Serial scan input |
| sample_bit | input | 1 | Serial test-data bit folded into the signature |
| tc_flag | output | 1 | Sticky flag: the running count reached zero |
| tdo | output | 1 | Serial scan output |
| signature | output | 16 | Present signature value |

## Verification
A control code, a load or a data bit applied before a rising edge takes effect on that edge. Control codes change only the enable, so the count and signature respond one edge later. The terminal flag is set on the edge after the count has been zero while running. A captured or shifted bit appears on `tdo` directly after the edge that moved it. The bench drives inputs after the falling edge and steps its own model at the rising edge. It compares the flag, the signature and `tdo` at the next falling edge. Its directed sequences count those edges by hand to reach the expected counts and signatures.

// File: rtl/tck_bist_pkg.sv
package tck_bist_pkg;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_CNT_RUN  = 3'd1,
        OP_CNT_HALT = 3'd2,
        OP_SIG_RUN  = 3'd3,
        OP_SIG_HALT = 3'd4
    } bist_op_e;

    typedef enum logic [1:0] {
        PATH_NONE = 2'd0,
        PATH_CNT  = 2'd1,
        PATH_SIG  = 2'd2,
        PATH_RSVD = 2'd3
    } scan_path_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } dr_strobe_t;

    typedef struct packed {
        logic cnt_run;
        logic sig_run;
    } bist_enable_t;

    localparam logic [15:0] SIG_POLY_CCITT = 16'h1021;

    function automatic logic path_is_live(input scan_path_e p);
        return (p == PATH_CNT) || (p == PATH_SIG);
    endfunction

endpackage

// File: rtl/bist_ctl_decode.sv
module bist_ctl_decode
    import tck_bist_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  bist_op_e     op,
    output bist_enable_t en
);
    bist_enable_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            unique case (op)
                OP_CNT_RUN:  en_q.cnt_run <= 1'b1;
                OP_CNT_HALT: en_q.cnt_run <= 1'b0;
                OP_SIG_RUN:  en_q.sig_run <= 1'b1;
                OP_SIG_HALT: en_q.sig_run <= 1'b0;
                default:     en_q <= en_q;
            endcase
        end
    end

    assign en = en_q;
endmodule

// File: rtl/tck_down_counter.sv
module tck_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             tc
);
    logic [CNT_W-1:0] count_q;
    logic             tc_q;
    logic             at_zero;

    assign at_zero = (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            tc_q    <= 1'b0;
        end else if (load) begin
            count_q <= load_val;
            tc_q    <= 1'b0;
        end else if (run) begin
            if (at_zero) begin
                tc_q <= 1'b1;
            end else begin
                count_q <= count_q - CNT_W'(1);
            end
        end
    end

    assign count = count_q;
    assign tc    = tc_q;
endmodule

// File: rtl/sig_compactor.sv
module sig_compactor #(
    parameter int             SIG_W = 16,
    parameter logic [SIG_W-1:0] POLY = 16'h1021
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             din,
    output logic [SIG_W-1:0] sig
);
    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] sig_nxt;
    logic             feedback;

    assign feedback = sig_q[SIG_W-1] ^ din;
    assign sig_nxt  = {sig_q[SIG_W-2:0], 1'b0} ^ (feedback ? POLY : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q <= '0;
        end else if (run) begin
            sig_q <= sig_nxt;
        end
    end

    assign sig = sig_q;
endmodule

// File: rtl/dr_stage.sv
module dr_stage
    import tck_bist_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SIG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  scan_path_e       path,
    input  dr_strobe_t       strobe,
    input  logic             tdi,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [SIG_W-1:0] sig_val,
    output logic [CNT_W-1:0] stage,
    output logic             ser_out
);
    logic [CNT_W-1:0] st_q;
    logic [CNT_W-1:0] st_nxt;
    logic [CNT_W-1:0] cnt_shifted;
    logic [CNT_W-1:0] sig_shifted;

    assign cnt_shifted = {tdi, st_q[CNT_W-1:1]};

    generate
        if (SIG_W < CNT_W) begin : g_short_sig
            assign sig_shifted = {st_q[CNT_W-1:SIG_W], tdi, st_q[SIG_W-1:1]};
        end else begin : g_full_sig
            assign sig_shifted = cnt_shifted;
        end
    endgenerate

    always_comb begin
        st_nxt = st_q;
        if (strobe.capture) begin
            case (path)
                PATH_CNT: st_nxt = cnt_val;
                PATH_SIG: st_nxt = CNT_W'(sig_val);
                default:  st_nxt = st_q;
            endcase
        end else if (strobe.shift) begin
            case (path)
                PATH_CNT: st_nxt = cnt_shifted;
                PATH_SIG: st_nxt = sig_shifted;
                default:  st_nxt = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_nxt;
        end
    end

    assign stage   = st_q;
    assign ser_out = path_is_live(path) ? st_q[0] : 1'b0;
endmodule

// File: rtl/tck_bist_unit.sv
module tck_bist_unit
    import tck_bist_pkg::*;
#(
    parameter int               CNT_W    = 32,
    parameter int               SIG_W    = 16,
    parameter logic [SIG_W-1:0] SIG_POLY = SIG_POLY_CCITT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ctl_op,
    input  logic [1:0]       path_sel,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    input  logic             sample_bit,
    output logic             tc_flag,
    output logic             tdo,
    output logic [SIG_W-1:0] signature
);
    localparam int STAGE_W = (CNT_W > SIG_W) ? CNT_W : SIG_W;

    bist_enable_t     en;
    scan_path_e       path;
    dr_strobe_t       strobe;
    logic [CNT_W-1:0] cnt_q;
    logic [STAGE_W-1:0] stage;
    logic             cnt_load;
    logic             cnt_en;
    logic             sig_en;

    assign path     = scan_path_e'(path_sel);
    assign strobe   = '{capture: capture_dr, shift: shift_dr, update: update_dr};
    assign cnt_load = strobe.update && (path == PATH_CNT);
    assign cnt_en   = en.cnt_run;
    assign sig_en   = en.sig_run;

    bist_ctl_decode u_decode (
        .clk (clk),
        .rst (rst),
        .op  (bist_op_e'(ctl_op)),
        .en  (en)
    );

    tck_down_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .run      (cnt_en),
        .load     (cnt_load),
        .load_val (stage[CNT_W-1:0]),
        .count    (cnt_q),
        .tc       (tc_flag)
    );

    sig_compactor #(.SIG_W(SIG_W), .POLY(SIG_POLY)) u_sig (
        .clk (clk),
        .rst (rst),
        .run (sig_en),
        .din (sample_bit),
        .sig (signature)
    );

    dr_stage #(.CNT_W(STAGE_W), .SIG_W(SIG_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .path    (path),
        .strobe  (strobe),
        .tdi     (tdi),
        .cnt_val (STAGE_W'(cnt_q)),
        .sig_val (signature),
        .stage   (stage),
        .ser_out (tdo)
    );
endmodule

// File: rtl/tck_bist_checker.sv
module tck_bist_checker #(
    parameter int CNT_W = 32,
    parameter int SIG_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       ctl_op,
    input logic [1:0]       path_sel,
    input logic             update_dr,
    input logic             cnt_en,
    input logic             sig_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic             tc_flag,
    input logic             tdo,
    input logic [SIG_W-1:0] signature
);
    logic load;
    assign load = update_dr && (path_sel == 2'd1);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (signature == '0 && !tc_flag && !cnt_en && !sig_en && cnt_q == '0));

    assert_cnt_start_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_op == 3'd1) |=> cnt_en);

    assert_cnt_halt_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_op == 3'd2) |=> !cnt_en);

    assert_cnt_dec_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));

    assert_tc_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (tc_flag && !load) |=> tc_flag);

    assert_tc_clear_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> !tc_flag);

    assert_tc_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_flag) |-> ($past(cnt_en) && $past(cnt_q) == '0));

    assert_sig_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !sig_en |=> $stable(signature));

    assert_sig_halt_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl_op == 3'd4) |=> !sig_en);

    assert_tdo_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (path_sel == 2'd0 || path_sel == 2'd3) |-> !tdo);
endmodule

bind tck_bist_unit tck_bist_checker #(.CNT_W(CNT_W), .SIG_W(SIG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_op    (ctl_op),
    .path_sel  (path_sel),
    .update_dr (update_dr),
    .cnt_en    (cnt_en),
    .sig_en    (sig_en),
    .cnt_q     (cnt_q),
    .tc_flag   (tc_flag),
    .tdo       (tdo),
    .signature (signature)
);

// File: tb/tb_tck_bist_unit.sv
module tb_tck_bist_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ctl_op = 3'd0;
    logic [1:0]  path_sel = 2'd0;
    logic        capture_dr = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdi = 1'b0;
    logic        sample_bit = 1'b0;
    logic        tc_flag;
    logic        tdo;
    logic [15:0] signature;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] m_cnt = '0;
    logic [31:0] m_st  = '0;
    logic [15:0] m_sig = '0;
    bit          m_tc = 0, m_cen = 0, m_sen = 0;

    tck_bist_unit dut (
        .clk(clk), .rst(rst), .ctl_op(ctl_op), .path_sel(path_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .sample_bit(sample_bit), .tc_flag(tc_flag), .tdo(tdo),
        .signature(signature)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [31:0] o_st, o_cnt;
        logic [15:0] o_sig;
        bit o_cen, o_sen, fb;
        if (rst) begin
            m_cnt = '0; m_st = '0; m_sig = '0; m_tc = 0; m_cen = 0; m_sen = 0;
            return;
        end
        o_st = m_st; o_cnt = m_cnt; o_sig = m_sig; o_cen = m_cen; o_sen = m_sen;
        if (ctl_op == 3'd1) m_cen = 1;
        if (ctl_op == 3'd2) m_cen = 0;
        if (ctl_op == 3'd3) m_sen = 1;
        if (ctl_op == 3'd4) m_sen = 0;
        if (update_dr && path_sel == 2'd1) begin
            m_cnt = o_st; m_tc = 0;
        end else if (o_cen) begin
            if (o_cnt == 0) m_tc = 1;
            else m_cnt = o_cnt - 1;
        end
        if (o_sen) begin
            fb = o_sig[15] ^ sample_bit;
            m_sig = (o_sig << 1) ^ (fb ? 16'h1021 : 16'h0000);
        end
        if (capture_dr) begin
            if (path_sel == 2'd1) m_st = o_cnt;
            else if (path_sel == 2'd2) m_st = {16'h0, o_sig};
        end else if (shift_dr) begin
            if (path_sel == 2'd1) m_st = {tdi, o_st[31:1]};
            else if (path_sel == 2'd2) m_st = {o_st[31:16], tdi, o_st[15:1]};
        end
    endtask

    // one clock: model steps at the rising edge, outputs compared at the falling edge
    task automatic tick();
        logic exp_tdo;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_tdo = (path_sel == 2'd1 || path_sel == 2'd2) ? m_st[0] : 1'b0;
        chk("R4 tc_flag", {31'b0, tc_flag}, {31'b0, m_tc});
        chk("R5 signature", {16'b0, signature}, {16'b0, m_sig});
        chk("R9 tdo", {31'b0, tdo}, {31'b0, exp_tdo});
    endtask

    task automatic op_tick(input logic [2:0] op);
        ctl_op = op; tick(); ctl_op = 3'd0;
    endtask

    task automatic load_count(input logic [31:0] v);
        path_sel = 2'd1;
        for (int i = 0; i < 32; i++) begin
            tdi = v[i]; shift_dr = 1'b1; tick();
        end
        shift_dr = 1'b0; tdi = 1'b0; update_dr = 1'b1; tick(); update_dr = 1'b0;
    endtask

    task automatic read_back(input logic [1:0] p, input int w, output logic [31:0] v);
        v = '0;
        path_sel = p; capture_dr = 1'b1; tick(); capture_dr = 1'b0;
        for (int i = 0; i < w; i++) begin
            v[i] = tdo; shift_dr = 1'b1; tick();
        end
        shift_dr = 1'b0; path_sel = 2'd0;
    endtask

    initial begin
        logic [31:0] v;
        logic [15:0] held;
        logic [31:0] lcg = 32'h1234_5678;
        // R1: reset
        tick(); tick();
        rst = 1'b0;
        chk("R1 tc after reset", {31'b0, tc_flag}, 32'd0);
        chk("R1 signature after reset", {16'b0, signature}, 32'd0);
        chk("R1 tdo after reset", {31'b0, tdo}, 32'd0);
        read_back(2'd1, 32, v);
        chk("R1 count after reset", v, 32'd0);

        // R2/R3/R7: load 20, run 6 edges, expect 14
        load_count(32'd20);
        op_tick(3'd1);
        repeat (5) tick();
        op_tick(3'd2);
        op_tick(3'd6);  // R2 unused code
        tick();
        read_back(2'd1, 32, v);
        chk("R3 R2 count after six decrements", v, 32'd14);
        chk("R4 no flag while nonzero", {31'b0, tc_flag}, 32'd0);

        // R4: flag timing
        load_count(32'd2);
        op_tick(3'd1);
        tick(); tick();
        chk("R4 flag not yet set", {31'b0, tc_flag}, 32'd0);
        tick();
        chk("R4 flag set after zero while running", {31'b0, tc_flag}, 32'd1);
        repeat (5) tick();
        chk("R4 flag sticky", {31'b0, tc_flag}, 32'd1);
        read_back(2'd1, 32, v);
        chk("R3 count holds at zero", v, 32'd0);

        // R7: load while running overrides decrement, and clears flag
        load_count(32'd9);
        chk("R4 flag cleared by load", {31'b0, tc_flag}, 32'd0);
        op_tick(3'd2);
        read_back(2'd1, 32, v);
        chk("R7 loaded count then one decrement", v, 32'd8);

        // R4: zero count while stopped never sets flag
        load_count(32'd0);
        repeat (3) tick();
        chk("R4 stopped zero leaves flag clear", {31'b0, tc_flag}, 32'd0);

        // R6: counter codes do not start the signature
        sample_bit = 1'b1;
        op_tick(3'd1);
        repeat (3) tick();
        op_tick(3'd2);
        chk("R6 signature untouched by counter", {16'b0, signature}, 32'd0);

        // R5: signature steps
        op_tick(3'd3);
        sample_bit = 1'b1; tick();
        chk("R5 first step", {16'b0, signature}, 32'h1021);
        sample_bit = 1'b0; tick();
        chk("R5 second step", {16'b0, signature}, 32'h2042);
        op_tick(3'd4);
        chk("R5 step on stop edge", {16'b0, signature}, 32'h4084);
        held = signature;
        sample_bit = 1'b1;
        repeat (4) tick();
        chk("R6 signature holds while stopped", {16'b0, signature}, {16'b0, held});

        // R8: read signature, update has no effect
        read_back(2'd2, 16, v);
        chk("R8 signature readback", v, {16'b0, held});
        path_sel = 2'd2; update_dr = 1'b1; tick(); update_dr = 1'b0;
        chk("R8 update leaves signature", {16'b0, signature}, {16'b0, held});

        // R9: reserved path code
        path_sel = 2'd3; shift_dr = 1'b1; tdi = 1'b1; tick(); shift_dr = 1'b0;
        chk("R9 tdo zero on code 3", {31'b0, tdo}, 32'd0);
        path_sel = 2'd0;

        // mixed stimulus, model compared every clock
        for (int n = 0; n < 3000; n++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            ctl_op     = (lcg[18:16] == 3'd0) ? lcg[22:20] : 3'd0;
            path_sel   = lcg[25:24];
            capture_dr = (lcg[28:26] == 3'd0);
            shift_dr   = lcg[29];
            update_dr  = (lcg[31:30] == 2'd0) && lcg[15];
            tdi        = lcg[14];
            sample_bit = lcg[13];
            tick();
        end
        ctl_op = 3'd0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1-to-end run actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule